// File: doc/BRIEF.md
# Dual Interval Timer Register Window

This block occupies a 4 KB register window holding two independent down-counting interval timers. It decodes each word access to one of the two timer slots, returns a fixed set of identification bytes at the top of the window, and answers every other offset with zero. Each timer advances on its own external tick-enable input. Each timer has its own interrupt line, and the two lines are ORed into one combined output.

Software programs a timer through its slot. It sets a reload value, picks a counting mode (periodic, one-shot or free-running), a counter width (16 or 32 bits) and a prescale ratio, then enables the timer. The timer raises a sticky flag each time its count is at zero when a prescaled tick arrives. The flag drives the timer's interrupt when the interrupt-enable bit is set. The tick inputs are expected to run at 1 MHz by default, and each can come from a different rate source. The read port is combinational from the address and has no side effects.

Top module: `dual_timer_window`

## Requirements
- R1: After reset, both timers read control 0x20 (interrupt enable set, stopped), reload value 0, count 0 and flag 0, and all three interrupt outputs are low.
- R2: Word offsets 0x000-0x01F address timer 0 and 0x020-0x03F address timer 1 with the same layout. Within a slot: +0x00 reload (a write also reloads the count), +0x04 count (read only), +0x08 control, +0x0C flag clear (write), +0x10 raw flag, +0x14 masked flag, +0x18 reload-only write, +0x1C reads zero.
- R3: Control bit 7 enables counting and bit 6 selects periodic mode. Each prescaled tick decrements the count. A tick that finds the count at zero sets the flag and reloads the reload value, so one period is reload+1 ticks.
- R4: With control bits 6 and 0 both clear the timer free-runs. Its limit is 0xFFFF when bit 1 is clear and 0xFFFFFFFF when bit 1 is set. A write to +0x00 in this mode sets the count to that limit, and a tick at zero sets the flag and reloads the limit.
- R5: Control bit 0 selects one-shot mode. The tick that finds zero sets the flag once, and the count then stays at zero until +0x00 or the control register is written.
- R6: Control bits 3:2 set the prescale. 0 gives one decrement per tick, 1 gives one per 16 ticks, 2 gives one per 256 ticks and 3 behaves like 0. A control write restarts the prescale phase.
- R7: A write to +0x00 replaces the count at once. A write to +0x18 changes only the value used at the next reload. A control write with bit 7 set reloads the count.
- R8: A write to +0x0C clears the flag unless a zero-crossing tick occurs in the same cycle. +0x14 and the timer's interrupt output equal the flag ANDed with control bit 5.
- R9: The combined interrupt output is high exactly when either timer interrupt is high.
- R10: Offsets 0xFE0, 0xFE4, ... 0xFFC read the bytes 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, zero-extended.
- R11: Offsets 0xF00, 0xF04 and all other offsets outside the timer slots and identification words read zero. Writes there, writes to the count register and writes to identification words change nothing.
- R12: Each timer counts only on its own tick input. Ticks on the other input leave its count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 12 | Byte offset in the window (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick0 | input | 1 | Tick enable for timer 0 |
| tick1 | input | 1 | Tick enable for timer 1 |
| irq0 | output | 1 | Timer 0 interrupt |
| irq1 | output | 1 | Timer 1 interrupt |
| irq_any | output | 1 | OR of both timer interrupts |

## Verification
The hardest case to reach from the ports is a zero-crossing in a narrow free-running timer. The count starts at 0xFFFF and wraps only after 65536 ticks. A directed sequence holds tick0 high for that whole stretch and then checks the reload and the flag. The divide-by-256 prescale edge is also slow to reach, so a directed run places the decrement on exactly the 256th tick. Random writes and ticks from a fixed seed then cover control rewrites while a timer runs and same-cycle clears against zero crossings. A bench model of the requirements predicts every result.

// File: rtl/dtw_pkg.sv
package dtw_pkg;

   typedef enum logic [2:0] {
      SLOT_RELOAD  = 3'd0,
      SLOT_COUNT   = 3'd1,
      SLOT_CTRL    = 3'd2,
      SLOT_ACK     = 3'd3,
      SLOT_RAWFLAG = 3'd4,
      SLOT_MSKFLAG = 3'd5,
      SLOT_SOFTLD  = 3'd6,
      SLOT_SPARE   = 3'd7
   } slot_reg_e;

   typedef struct packed {
      logic       run;
      logic       periodic;
      logic       irq_en;
      logic       spare;
      logic [1:0] scale;
      logic       wide;
      logic       single;
   } tmr_ctrl_t;

   localparam logic [7:0] CTRL_AT_RESET = 8'h20;
   localparam int unsigned NARROW_W     = 16;

   function automatic logic [7:0] ident_byte(input logic [2:0] idx);
      logic [7:0] b;
      case (idx)
         3'd0:    b = 8'h04;
         3'd1:    b = 8'h18;
         3'd2:    b = 8'h14;
         3'd3:    b = 8'h00;
         3'd4:    b = 8'h0D;
         3'd5:    b = 8'hF0;
         3'd6:    b = 8'h05;
         default: b = 8'hB1;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/dtw_prescale.sv
module dtw_prescale #(
   parameter int unsigned LOG_LO = 4,
   parameter int unsigned LOG_HI = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  logic       clr_i,
   input  logic       tick_i,
   input  logic [1:0] sel_i,
   output logic       stb_o
);
   localparam int unsigned PH_W = LOG_HI;

   if (LOG_LO < 1 || LOG_HI <= LOG_LO) begin : g_bad_ratio
      $error("dtw_prescale: need 1 <= LOG_LO < LOG_HI");
   end

   logic [PH_W-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              phase_q <= '0;
      else if (clr_i)          phase_q <= '0;
      else if (tick_i && en_i) phase_q <= phase_q + 1'b1;
   end

   always_comb begin
      case (sel_i)
         2'd1:    stb_o = tick_i && (&phase_q[LOG_LO-1:0]);
         2'd2:    stb_o = tick_i && (&phase_q);
         default: stb_o = tick_i;
      endcase
   end

endmodule

// File: rtl/dtw_timer.sv
module dtw_timer
   import dtw_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LOG_LO = 4,
   parameter int unsigned LOG_HI = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              wr_i,
   input  logic [2:0]        off_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o
);
   localparam logic [DATA_W-1:0] NARROW_MASK = DATA_W'({NARROW_W{1'b1}});

   if (DATA_W < 32) begin : g_bad_width
      $error("dtw_timer: DATA_W must be at least 32");
   end

   tmr_ctrl_t         ctrl_q, ctrl_new;
   logic [DATA_W-1:0] rel_q, cnt_q;
   logic              flag_q, halt_q;
   logic              wr_rel, wr_ctl, wr_soft, wr_ack;
   logic              stb, step, fire;

   function automatic logic [DATA_W-1:0] limit_of(input tmr_ctrl_t c,
                                                   input logic [DATA_W-1:0] v);
      logic [DATA_W-1:0] m;
      m = c.wide ? '1 : NARROW_MASK;
      return (c.single || c.periodic) ? (v & m) : m;
   endfunction

   assign wr_rel   = wr_i && (off_i == SLOT_RELOAD);
   assign wr_ctl   = wr_i && (off_i == SLOT_CTRL);
   assign wr_soft  = wr_i && (off_i == SLOT_SOFTLD);
   assign wr_ack   = wr_i && (off_i == SLOT_ACK);
   assign ctrl_new = tmr_ctrl_t'(wdata_i[7:0]);

   dtw_prescale #(.LOG_LO(LOG_LO), .LOG_HI(LOG_HI)) u_scale (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (ctrl_q.run),
      .clr_i  (wr_ctl),
      .tick_i (tick_i),
      .sel_i  (ctrl_q.scale),
      .stb_o  (stb)
   );

   assign step = stb && ctrl_q.run && !halt_q && !wr_rel && !wr_ctl;
   assign fire = step && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= tmr_ctrl_t'(CTRL_AT_RESET);
         rel_q  <= '0;
         cnt_q  <= '0;
         flag_q <= 1'b0;
         halt_q <= 1'b0;
      end else begin
         if (wr_rel || wr_soft) rel_q <= wdata_i;
         if (wr_ctl) ctrl_q <= ctrl_new;

         if (wr_rel) begin
            cnt_q  <= limit_of(ctrl_q, wdata_i);
            halt_q <= 1'b0;
         end else if (wr_ctl) begin
            halt_q <= 1'b0;
            if (ctrl_new.run)        cnt_q <= limit_of(ctrl_new, rel_q);
            else if (!ctrl_new.wide) cnt_q <= cnt_q & NARROW_MASK;
         end else if (step) begin
            if (cnt_q == '0) begin
               if (ctrl_q.single) halt_q <= 1'b1;
               else               cnt_q  <= limit_of(ctrl_q, rel_q);
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end

         if (fire)        flag_q <= 1'b1;
         else if (wr_ack) flag_q <= 1'b0;
      end
   end

   always_comb begin
      case (slot_reg_e'(off_i))
         SLOT_RELOAD, SLOT_SOFTLD: rdata_o = rel_q;
         SLOT_COUNT:               rdata_o = cnt_q;
         SLOT_CTRL:                rdata_o = {{(DATA_W-8){1'b0}}, ctrl_q};
         SLOT_RAWFLAG:             rdata_o = DATA_W'(flag_q);
         SLOT_MSKFLAG:             rdata_o = DATA_W'(flag_q && ctrl_q.irq_en);
         default:                  rdata_o = '0;
      endcase
   end

   assign irq_o = flag_q && ctrl_q.irq_en;

   // R12: no tick and no access leaves the count untouched
   a_r12_still_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !wr_i) |=> $stable(cnt_q));

   // R8: the flag can only rise after a prescaled strobe
   a_r8_flag_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(stb));

   // R8: a clear with no strobe in the same cycle empties the flag
   a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ack && !stb) |=> !flag_q);

   // R5: a finished one-shot stays at zero while nothing is written
   a_r5_single_parks: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && !wr_i) |=> (halt_q && cnt_q == '0));

   // R4: a narrow timer never holds a count above 16 bits
   a_r4_narrow_fits: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q.wide |-> (cnt_q[DATA_W-1:NARROW_W] == '0));

endmodule

// File: rtl/dtw_id_rom.sv
module dtw_id_rom
   import dtw_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [2:0]        idx_i,
   output logic [DATA_W-1:0] val_o
);
   if (DATA_W < 8) begin : g_bad_width
      $error("dtw_id_rom: DATA_W must hold a byte");
   end

   assign val_o = DATA_W'(ident_byte(idx_i));

endmodule

// File: rtl/dual_timer_window.sv
module dual_timer_window #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LOG_LO = 4,
   parameter int unsigned LOG_HI = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              tick0,
   input  logic              tick1,
   output logic              irq0,
   output logic              irq1,
   output logic              irq_any
);
   localparam int unsigned N_TMR    = 2;
   localparam int unsigned WORD_LSB = 2;
   localparam int unsigned SLOT_LSB = 5;

   if (ADDR_W != 12) begin : g_bad_addr
      $error("dual_timer_window: the window is 4 KB, ADDR_W must be 12");
   end

   logic [N_TMR-1:0]  tick_v, irq_v;
   logic [DATA_W-1:0] slot_rd [N_TMR];
   logic [DATA_W-1:0] ident_w;
   logic              in_tmr, in_ident;
   logic              unused_lo;

   assign unused_lo = ^bus_addr[WORD_LSB-1:0];
   assign in_tmr    = (bus_addr[ADDR_W-1:SLOT_LSB+1] == '0);
   assign in_ident  = (bus_addr[ADDR_W-1:SLOT_LSB] == '1);
   assign tick_v    = {tick1, tick0};

   for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
      dtw_timer #(.DATA_W(DATA_W), .LOG_LO(LOG_LO), .LOG_HI(LOG_HI)) u_tmr (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick_i  (tick_v[g]),
         .wr_i    (bus_wr && in_tmr && (bus_addr[SLOT_LSB] == 1'(g))),
         .off_i   (bus_addr[SLOT_LSB-1:WORD_LSB]),
         .wdata_i (bus_wdata),
         .rdata_o (slot_rd[g]),
         .irq_o   (irq_v[g])
      );
   end

   dtw_id_rom #(.DATA_W(DATA_W)) u_ident (
      .idx_i (bus_addr[SLOT_LSB-1:WORD_LSB]),
      .val_o (ident_w)
   );

   always_comb begin
      bus_rdata = '0;
      if (in_tmr)        bus_rdata = slot_rd[bus_addr[SLOT_LSB]];
      else if (in_ident) bus_rdata = ident_w;
   end

   assign irq0    = irq_v[0];
   assign irq1    = irq_v[1];
   assign irq_any = |irq_v;

   // R9: the merged line only rises together with one of its sources
   a_r9_merge_follows: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_any) |-> ($rose(irq0) || $rose(irq1)));

   // R11: writes outside the slots, with no ticks, leave both interrupts alone
   a_r11_outside_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !in_tmr && !tick0 && !tick1) |=> ($stable(irq0) && $stable(irq1)));

endmodule

// File: tb/test_dual_timer_window.sv
module test_dual_timer_window;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tick0 = 1'b0;
   logic        tick1 = 1'b0;
   logic        irq0, irq1, irq_any;

   int n_chk = 0;
   int n_err = 0;

   logic [31:0] m_ld [2];
   logic [31:0] m_cn [2];
   logic [7:0]  m_ct [2];
   logic [7:0]  m_pc [2];
   bit          m_fl [2];
   bit          m_dn [2];

   always #10 clk = ~clk;

   dual_timer_window i_dual_timer_window (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .tick0     (tick0),
      .tick1     (tick1),
      .irq0      (irq0),
      .irq1      (irq1),
      .irq_any   (irq_any)
   );

   function automatic logic [7:0] id_exp(input logic [2:0] k);
      logic [7:0] t [8] = '{8'h04, 8'h18, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      return t[k];
   endfunction

   function automatic logic [31:0] f_lim(input logic [7:0] c, input logic [31:0] v);
      logic [31:0] m;
      m = c[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
      return (c[0] || c[6]) ? (v & m) : m;
   endfunction

   function automatic logic [31:0] m_rd(input logic [11:0] a);
      int i;
      i = int'(a[5]);
      if (a[11:6] == 6'd0) begin
         case (a[4:2])
            3'd0, 3'd6: return m_ld[i];
            3'd1:       return m_cn[i];
            3'd2:       return {24'd0, m_ct[i]};
            3'd4:       return {31'd0, m_fl[i]};
            3'd5:       return {31'd0, m_fl[i] && m_ct[i][5]};
            default:    return 32'd0;
         endcase
      end
      if (a[11:5] == 7'h7F) return {24'd0, id_exp(a[4:2])};
      return 32'd0;
   endfunction

   task automatic m_step(input int i, input bit wr, input logic [2:0] off,
                         input logic [31:0] d, input bit tk);
      bit wl, wc, wb, wi, strobe, stp;
      wl = wr && off == 3'd0;
      wc = wr && off == 3'd2;
      wb = wr && off == 3'd6;
      wi = wr && off == 3'd3;
      case (m_ct[i][3:2])
         2'd1:    strobe = tk && (m_pc[i][3:0] == 4'hF);
         2'd2:    strobe = tk && (m_pc[i] == 8'hFF);
         default: strobe = tk;
      endcase
      stp = strobe && m_ct[i][7] && !m_dn[i] && !wl && !wc;
      if (wc) m_pc[i] = 8'd0;
      else if (tk && m_ct[i][7]) m_pc[i] = m_pc[i] + 8'd1;
      if (stp && m_cn[i] == 32'd0) m_fl[i] = 1'b1;
      else if (wi) m_fl[i] = 1'b0;
      if (wl) begin
         m_cn[i] = f_lim(m_ct[i], d);
         m_dn[i] = 1'b0;
      end else if (wc) begin
         m_dn[i] = 1'b0;
         if (d[7])       m_cn[i] = f_lim(d[7:0], m_ld[i]);
         else if (!d[1]) m_cn[i] = m_cn[i] & 32'h0000_FFFF;
      end else if (stp) begin
         if (m_cn[i] == 32'd0) begin
            if (m_ct[i][0]) m_dn[i] = 1'b1;
            else            m_cn[i] = f_lim(m_ct[i], m_ld[i]);
         end else begin
            m_cn[i] = m_cn[i] - 32'd1;
         end
      end
      if (wl || wb) m_ld[i] = d;
      if (wc) m_ct[i] = d[7:0];
   endtask

   task automatic cyc(input bit wr, input logic [11:0] a, input logic [31:0] d,
                      input bit t0, input bit t1);
      bus_wr = wr; bus_addr = a; bus_wdata = d; tick0 = t0; tick1 = t1;
      @(posedge clk);
      for (int i = 0; i < 2; i++)
         m_step(i, wr && a[11:6] == 6'd0 && int'(a[5]) == i, a[4:2], d,
                (i == 0) ? t0 : t1);
      @(negedge clk);
      bus_wr = 1'b0; tick0 = 1'b0; tick1 = 1'b0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      cyc(1'b1, a, d, 1'b0, 1'b0);
   endtask

   task automatic tk(input int n, input bit t0, input bit t1);
      for (int k = 0; k < n; k++) cyc(1'b0, 12'h000, 32'd0, t0, t1);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic rdm(input logic [11:0] a, input string tag);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, m_rd(a));
   endtask

   task automatic rdv(input logic [11:0] a, input logic [31:0] exp, input string tag);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp);
      chk({tag, " model"}, bus_rdata, m_rd(a));
   endtask

   task automatic pins(input string tag);
      bit e0, e1;
      e0 = m_fl[0] && m_ct[0][5];
      e1 = m_fl[1] && m_ct[1][5];
      chk(tag, {29'd0, irq_any, irq1, irq0}, {29'd0, e0 || e1, e1, e0});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      int unsigned seed_set;
      seed_set = $urandom(32'd4242);
      for (int i = 0; i < 2; i++) begin
         m_ld[i] = '0; m_cn[i] = '0; m_ct[i] = 8'h20;
         m_pc[i] = '0; m_fl[i] = 1'b0; m_dn[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rdv(12'h008, 32'h20, "R1 ctrl t0");
      rdv(12'h028, 32'h20, "R1 ctrl t1");
      rdv(12'h004, 32'h0, "R1 count t0");
      rdv(12'h000, 32'h0, "R1 reload t0");
      rdv(12'h030, 32'h0, "R1 flag t1");
      pins("R1 irq pins");

      // R10 identification, R11 unmapped reads
      for (int k = 0; k < 8; k++)
         rdv(12'hFE0 + 12'(4 * k), {24'd0, id_exp(3'(k))}, "R10 ident byte");
      rdv(12'hF00, 32'h0, "R11 test reg F00");
      rdv(12'hF04, 32'h0, "R11 test reg F04");
      rdv(12'h040, 32'h0, "R11 past slots");
      rdv(12'h800, 32'h0, "R11 middle");
      rdv(12'h01C, 32'h0, "R2 spare word");

      // R4 / R7: reload write while free-running narrow
      wr(12'h000, 32'd3);
      rdv(12'h004, 32'h0000_FFFF, "R4 load in free mode");
      wr(12'h008, 32'hE2);
      rdv(12'h004, 32'd3, "R7 enable reloads");
      tk(3, 1'b1, 1'b0);
      rdv(12'h004, 32'd0, "R3 counted to zero");
      rdv(12'h010, 32'd0, "R3 no flag yet");
      tk(1, 1'b1, 1'b0);
      rdv(12'h004, 32'd3, "R3 periodic reload");
      rdv(12'h010, 32'd1, "R3 raw flag");
      rdv(12'h014, 32'd1, "R8 masked flag");
      chk("R9 irq_any", {31'd0, irq_any}, 32'd1);
      pins("R8 pins after fire");

      // R7 background reload
      wr(12'h018, 32'd7);
      rdv(12'h004, 32'd3, "R7 soft load keeps count");
      rdv(12'h000, 32'd7, "R7 soft load value");
      tk(4, 1'b1, 1'b0);
      rdv(12'h004, 32'd7, "R7 next reload");

      // R8 clear and mask
      wr(12'h00C, 32'd0);
      rdv(12'h010, 32'd0, "R8 cleared");
      pins("R8 pins cleared");
      wr(12'h008, 32'hC2);
      tk(8, 1'b1, 1'b0);
      rdv(12'h010, 32'd1, "R8 raw with mask off");
      rdv(12'h014, 32'd0, "R8 masked off");
      pins("R8 pins masked");

      // R12 / R2 timer 1 alone
      wr(12'h020, 32'd2);
      wr(12'h028, 32'hE2);
      rdv(12'h020, 32'd2, "R2 slot 1 reload");
      tk(3, 1'b0, 1'b1);
      rdv(12'h004, 32'd7, "R12 t0 untouched");
      rdv(12'h030, 32'd1, "R2 slot 1 flag");
      chk("R9 irq1 drives any", {30'd0, irq_any, irq1}, 32'd3);
      pins("R9 pins");

      // R11 ignored writes
      wr(12'h004, 32'h55);
      wr(12'h040, 32'h1234);
      wr(12'hFE0, 32'hFF);
      wr(12'hF00, 32'h1);
      wr(12'hF04, 32'h1);
      rdv(12'h004, 32'd7, "R11 count write ignored");
      rdv(12'hFE0, 32'h04, "R11 ident unchanged");
      rdv(12'h008, 32'hC2, "R11 ctrl t0 kept");
      rdv(12'h028, 32'hE2, "R11 ctrl t1 kept");
      rdv(12'hF00, 32'h0, "R11 test reg still zero");

      // R5 one-shot
      wr(12'h00C, 32'd0);
      wr(12'h000, 32'd1);
      wr(12'h008, 32'hA3);
      tk(2, 1'b1, 1'b0);
      rdv(12'h010, 32'd1, "R5 fired once");
      rdv(12'h004, 32'd0, "R5 parked at zero");
      wr(12'h00C, 32'd0);
      tk(5, 1'b1, 1'b0);
      rdv(12'h010, 32'd0, "R5 no second fire");
      rdv(12'h004, 32'd0, "R5 still zero");

      // R6 prescale
      wr(12'h000, 32'd1);
      wr(12'h008, 32'hE6);
      tk(15, 1'b1, 1'b0);
      rdv(12'h004, 32'd1, "R6 div16 before edge");
      tk(1, 1'b1, 1'b0);
      rdv(12'h004, 32'd0, "R6 div16 at edge");
      wr(12'h008, 32'hEA);
      tk(255, 1'b1, 1'b0);
      rdv(12'h004, 32'd1, "R6 div256 before edge");
      tk(1, 1'b1, 1'b0);
      rdv(12'h004, 32'd0, "R6 div256 at edge");
      wr(12'h008, 32'hEE);
      tk(1, 1'b1, 1'b0);
      rdv(12'h004, 32'd0, "R6 code 3 as div1");

      // R4 free-running wrap
      wr(12'h00C, 32'd0);
      wr(12'h008, 32'h00);
      wr(12'h000, 32'd5);
      rdv(12'h004, 32'h0000_FFFF, "R4 narrow limit");
      rdv(12'h000, 32'd5, "R4 reload kept");
      wr(12'h008, 32'h80);
      tk(1, 1'b1, 1'b0);
      rdv(12'h004, 32'h0000_FFFE, "R4 first step");
      tk(65534, 1'b1, 1'b0);
      rdv(12'h004, 32'd0, "R4 reached zero");
      rdv(12'h010, 32'd0, "R4 no flag before wrap");
      tk(1, 1'b1, 1'b0);
      rdv(12'h004, 32'h0000_FFFF, "R4 wrap to limit");
      rdv(12'h010, 32'd1, "R4 flag on wrap");
      wr(12'h008, 32'h82);
      rdv(12'h004, 32'hFFFF_FFFF, "R4 wide limit");
      tk(1, 1'b1, 1'b0);
      rdv(12'h004, 32'hFFFF_FFFE, "R4 wide step");

      // random phase
      for (int it = 0; it < 3000; it++) begin
         int unsigned r;
         logic [11:0] a;
         logic [31:0] d;
         logic [2:0]  off;
         r = $urandom % 100;
         if (r < 18) begin
            off = 3'($urandom % 8);
            case (off)
               3'd0, 3'd6: d = $urandom % 24;
               3'd2:       d = $urandom & 32'hFF;
               default:    d = $urandom;
            endcase
            a = {6'd0, 1'($urandom % 2), off, 2'b00};
            if (r < 2) a = 12'h040 + 12'(($urandom % 960) * 4);
            cyc(1'b1, a, d, 1'($urandom % 2), 1'($urandom % 2));
         end else begin
            cyc(1'b0, 12'h000, 32'd0, 1'($urandom % 2), 1'($urandom % 2));
         end
         pins("R9 random pins");
         a = 12'(($urandom % 64) * 4);
         if (it % 5 == 0) a = 12'hFE0 + 12'(($urandom % 8) * 4);
         rdm(a, "R3 random read");
      end

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule